// File: doc/BRIEF.md
# Modulo Tick Counter with Overflow Flag

This block counts external tick strobes in an 8-bit up-counter. The counter returns to zero on the tick after it has reached a programmable modulo value. That return to zero sets a sticky overflow flag, and the flag drives an interrupt request when interrupts are enabled. Software reaches the block through a small synchronous register port with three addresses: control/status, counter and modulo. There is no prescaler in the block: any upstream divider only has to pulse `tick_i` for one clock per count.

The register port is a plain single-cycle port and has no valid/ready handshake. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is combinational and valid in the cycle where `bus_rd` is high. Both accesses complete in one cycle, and the block never applies back-pressure.

The overflow flag guards against losing an event. A write of 0 to the flag clears it only when a read of the control/status register saw the flag set beforehand. If a new overflow arrives in between, or in the same cycle as any clearing action, the flag stays set.

Top module: `modtmr_top`

## Requirements
- R1: After reset, the control/status register (address 0) reads 0x10, meaning the stop bit is set and the flag and interrupt enable are clear. The counter (address 1) and the modulo register (address 2) read 0x00, and `irq_o` is 0.
- R2: In the control/status register, bit 7 is the flag, bit 6 is the interrupt enable, bit 5 is the reset strobe and bit 4 is the stop bit. Bits 3:0 and bit 5 always read 0.
- R3: When the stop bit is 0, each clock with `tick_i` high adds one to the counter. If the counter already equals the modulo value, that tick sets it to 0x00 instead and sets the flag.
- R4: When the stop bit is 1, ticks leave the counter unchanged. After the stop bit is cleared, counting continues from the held value.
- R5: A control/status write with bit 7 = 0 clears the flag only if an earlier read of that register returned the flag as 1 and no other control/status write came in between. Without such a read, the flag stays set.
- R6: Writing 1 to bit 5 of the control/status register sets the counter to 0x00 and clears the flag. Writing 0 to bit 5 leaves the counter unchanged.
- R7: Any write to the modulo register loads the new value, clears the flag and sets the counter to 0x00.
- R8: Any write to the counter address sets the counter to 0x00.
- R9: `irq_o` is 1 exactly when the interrupt enable and the flag are both 1.
- R10: An overflow in the same cycle as a clearing action leaves the flag set. An overflow between the arming read and the clearing write makes that write leave the flag set.
- R11: With a modulo value of 0x00, the counter stays at 0x00 and every enabled tick sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count strobe, one count per high clock |
| bus_addr | input | 2 | Register address: 0 control/status, 1 counter, 2 modulo |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; arms the flag clear |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd`, 0 otherwise |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The assertions are checked on every cycle and cover:
- the increment and the wrap of the counter,
- the hold while stopped,
- the priority of overflow over clearing,
- the clear caused by a modulo write,
- an un-armed write of 0 leaving the flag set,
- the zero bits in the control/status read value,
- `irq_o` never being high without the flag.

The read-then-write clear handshake spans several accesses, and so do resuming from a held count and a modulo of zero. These only appear in the bench's scenarios. The bench compares each read value against a cycle model kept in the bench.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int DATA_W = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_MOD  = 2'd2;
  localparam int BIT_FLAG = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_STB  = 5;
  localparam int BIT_STOP = 4;
  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h10;
endpackage

// File: rtl/modtmr_count.sv
module modtmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic at_top;

  assign at_top = (cnt_q == modv);
  // A wrap is reported even when a clear lands in the same cycle, so overflow wins.
  assign wrap = adv && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (adv)    cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic rd_ctrl,
  input  logic wr_ctrl,
  input  logic wr_flag_bit,
  input  logic hard_clr,
  output logic flag_q,
  output logic arm_q
);
  logic soft_clr;

  assign soft_clr = wr_ctrl && arm_q && !wr_flag_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (ovf)                  flag_q <= 1'b1;
    else if (hard_clr || soft_clr) flag_q <= 1'b0;
  end

  // Arming is consumed by any control write and lost on a new overflow or hard clear.
  always_ff @(posedge clk) begin
    if (!rst_n)                             arm_q <= 1'b0;
    else if (ovf || wr_ctrl || hard_clr)    arm_q <= 1'b0;
    else if (rd_ctrl && flag_q)             arm_q <= 1'b1;
  end
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
  import modtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic              ie_q,
  output logic              stop_q,
  output logic [CNT_W-1:0]  mod_q,
  output logic              wr_ctrl,
  output logic              strobe,
  output logic              mod_wr,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] mux;

  assign wr_ctrl = wr && (addr == ADDR_CTRL);
  assign mod_wr  = wr && (addr == ADDR_MOD);
  assign cnt_wr  = wr && (addr == ADDR_CNT);
  assign strobe  = wr_ctrl && wdata[BIT_STB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= CTRL_RESET[BIT_IE];
      stop_q <= CTRL_RESET[BIT_STOP];
    end else if (wr_ctrl) begin
      ie_q   <= wdata[BIT_IE];
      stop_q <= wdata[BIT_STOP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mod_q <= '0;
    else if (mod_wr) mod_q <= wdata[CNT_W-1:0];
  end

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[BIT_FLAG] = flag;
    ctrl_view[BIT_IE]   = ie_q;
    ctrl_view[BIT_STOP] = stop_q;
  end

  always_comb begin
    mux = '0;
    unique case (addr)
      ADDR_CTRL: mux = ctrl_view;
      ADDR_CNT:  mux[CNT_W-1:0] = cnt;
      ADDR_MOD:  mux[CNT_W-1:0] = mod_q;
      default:   mux = '0;
    endcase
  end

  assign rdata = rd ? mux : '0;
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_q;
  logic ie_q, stop_q, flag_q, arm_q;
  logic wr_ctrl, strobe, mod_wr, cnt_wr;
  logic adv, cnt_clr, ovf_evt, rd_ctrl;

  assign adv     = tick_i && !stop_q;
  assign cnt_clr = strobe || mod_wr || cnt_wr;
  assign rd_ctrl = bus_rd && (bus_addr == ADDR_CTRL);

  modtmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cnt(cnt_q), .flag(flag_q), .ie_q(ie_q),
    .stop_q(stop_q), .mod_q(mod_q), .wr_ctrl(wr_ctrl), .strobe(strobe),
    .mod_wr(mod_wr), .cnt_wr(cnt_wr), .rdata(bus_rdata)
  );

  modtmr_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(cnt_clr), .modv(mod_q),
    .cnt_q(cnt_q), .wrap(ovf_evt)
  );

  modtmr_flag flag_i (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_evt), .rd_ctrl(rd_ctrl),
    .wr_ctrl(wr_ctrl), .wr_flag_bit(bus_wdata[BIT_FLAG]),
    .hard_clr(strobe || mod_wr), .flag_q(flag_q), .arm_q(arm_q)
  );

  assign irq_o = ie_q && flag_q;
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] mod_q,
  input logic             stop_q,
  input logic             flag_q,
  input logic             arm_q
);
  logic clr_any;
  logic ovf_now;
  assign clr_any = bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2 ||
                              (bus_addr == 2'd0 && bus_wdata[5]));
  assign ovf_now = tick_i && !stop_q && (cnt_q == mod_q);

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !stop_q && cnt_q != mod_q && !clr_any) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_now && !clr_any) |=> (cnt_q == '0) && flag_q);

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clr_any) |=> $stable(cnt_q));

  p_ovf_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_now |=> flag_q);

  p_mod_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !ovf_now) |=> !flag_q && cnt_q == '0);

  p_unarmed_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q && bus_wr && bus_addr == 2'd0 && !bus_wdata[5]) |=> flag_q);

  p_ctrl_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |-> bus_rdata[3:0] == 4'h0 && !bus_rdata[5]);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_q);
endmodule

bind modtmr_top modtmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .cnt_q(cnt_q), .mod_q(mod_q),
  .stop_q(stop_q), .flag_q(flag_q), .arm_q(arm_q)
);

// File: tb/modtmr_top_tb_top.sv
module modtmr_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the architectural state
  logic [7:0] m_cnt = '0, m_mod = '0;
  logic m_flag = 1'b0, m_arm = 1'b0, m_ie = 1'b0, m_stop = 1'b1;

  always #10 clk = ~clk;

  modtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] read_value(input logic [1:0] a);
    case (a)
      2'd0: return {m_flag, m_ie, 1'b0, m_stop, 4'h0};
      2'd1: return m_cnt;
      2'd2: return m_mod;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic tk, input logic rd, input logic wr,
                            input logic [1:0] a, input logic [7:0] wd);
    logic cw, ovf, clr, hard;
    cw   = wr && a == 2'd0;
    ovf  = tk && !m_stop && m_cnt == m_mod;
    hard = (cw && wd[5]) || (wr && a == 2'd2);
    clr  = hard || (wr && a == 2'd1);
    if (ovf) m_flag = 1'b1;
    else if (hard || (cw && m_arm && !wd[7])) m_flag = 1'b0;
    if (ovf || cw || hard) m_arm = 1'b0;
    else if (rd && a == 2'd0 && read_value(2'd0)[7]) m_arm = 1'b1;
    if (clr) m_cnt = '0;
    else if (tk && !m_stop) m_cnt = (m_cnt == m_mod) ? 8'h00 : m_cnt + 8'h01;
    if (wr && a == 2'd2) m_mod = wd;
    if (cw) begin m_ie = wd[6]; m_stop = wd[4]; end
  endtask

  // one bus cycle: drive at negedge, sample 1 ns later, model updates at posedge
  task automatic cyc(input string req, input logic tk, input logic rd, input logic wr,
                     input logic [1:0] a, input logic [7:0] wd);
    logic f_before;
    @(negedge clk);
    tick_i = tk; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    if (rd) check(req, bus_rdata, read_value(a));
    check("R9", {7'd0, irq_o}, {7'd0, m_ie && m_flag});
    @(posedge clk);
    f_before = m_flag;
    model_step(tk, rd, wr, a, wd);
  endtask

  task automatic idle(input string req);
    cyc(req, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
  endtask
  task automatic wr_reg(input string req, input logic [1:0] a, input logic [7:0] d);
    cyc(req, 1'b0, 1'b0, 1'b1, a, d);
  endtask
  task automatic rd_reg(input string req, input logic [1:0] a);
    cyc(req, 1'b0, 1'b1, 1'b0, a, 8'h00);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc("R3", 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  // plain expected values for the directed corners
  task automatic expect_rd(input string req, input logic [1:0] a, input logic [7:0] e);
    @(negedge clk);
    tick_i = 1'b0; bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = 8'h00;
    #1;
    check(req, bus_rdata, e);
    @(posedge clk);
    model_step(1'b0, 1'b1, 1'b0, a, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed_junk;
    seed_junk = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    expect_rd("R1", 2'd0, 8'h10);
    expect_rd("R1", 2'd1, 8'h00);
    expect_rd("R1", 2'd2, 8'h00);
    ticks(3);
    expect_rd("R1", 2'd1, 8'h00);

    // R2 unused and strobe bits read zero
    wr_reg("R2", 2'd0, 8'hFF);
    expect_rd("R2", 2'd0, 8'h50);
    wr_reg("R2", 2'd0, 8'h00);

    // R3 count and wrap at modulo 3
    wr_reg("R7", 2'd2, 8'h03);
    ticks(3);
    expect_rd("R3", 2'd1, 8'h03);
    wr_reg("R5", 2'd0, 8'h00);   // flag still 0: harmless
    ticks(1);
    expect_rd("R3", 2'd1, 8'h00);

    // R5 write of 0 without arming read keeps the flag
    wr_reg("R5", 2'd0, 8'h00);
    expect_rd("R5", 2'd0, 8'h80);   // arms
    wr_reg("R5", 2'd0, 8'h00);
    expect_rd("R5", 2'd0, 8'h00);

    // R4 stop holds, resume continues
    ticks(2);
    wr_reg("R4", 2'd0, 8'h10);
    ticks(4);
    expect_rd("R4", 2'd1, 8'h02);
    wr_reg("R4", 2'd0, 8'h00);
    ticks(1);
    expect_rd("R4", 2'd1, 8'h03);

    // R6 strobe: write 0 no effect, write 1 clears counter and flag
    ticks(1);                         // wrap, flag set
    ticks(2);
    wr_reg("R6", 2'd0, 8'h00);
    expect_rd("R6", 2'd1, 8'h02);
    wr_reg("R6", 2'd0, 8'h20);
    expect_rd("R6", 2'd1, 8'h00);
    expect_rd("R6", 2'd0, 8'h00);

    // R9 interrupt with enable
    ticks(4);
    wr_reg("R9", 2'd0, 8'h40);
    expect_rd("R9", 2'd0, 8'hC0);
    idle("R9");

    // R7 modulo write clears flag and counter
    ticks(2);
    wr_reg("R7", 2'd2, 8'h05);
    expect_rd("R7", 2'd0, 8'h40);
    expect_rd("R7", 2'd1, 8'h00);
    expect_rd("R7", 2'd2, 8'h05);

    // R8 counter address write resets counter
    ticks(3);
    wr_reg("R8", 2'd1, 8'hAA);
    expect_rd("R8", 2'd1, 8'h00);

    // R10 overflow between arming read and clearing write
    wr_reg("R10", 2'd2, 8'h01);
    ticks(2);                         // wrap, flag 1
    expect_rd("R10", 2'd0, 8'hC0);   // arms
    ticks(2);                         // new wrap
    wr_reg("R10", 2'd0, 8'h40);
    expect_rd("R10", 2'd0, 8'hC0);
    // R10 overflow in same cycle as armed clearing write
    ticks(1);                         // cnt 1 == mod
    cyc("R10", 1'b1, 1'b0, 1'b1, 2'd0, 8'h40);
    expect_rd("R10", 2'd0, 8'hC0);   // flag kept, read arms again
    wr_reg("R10", 2'd0, 8'h40);
    expect_rd("R10", 2'd0, 8'h40);

    // R11 modulo 0
    wr_reg("R11", 2'd2, 8'h00);
    wr_reg("R11", 2'd0, 8'h00);
    ticks(1);
    expect_rd("R11", 2'd0, 8'h80);
    wr_reg("R11", 2'd0, 8'h00);      // armed clear
    ticks(1);
    expect_rd("R11", 2'd0, 8'h80);
    expect_rd("R11", 2'd1, 8'h00);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [1:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      a = 2'($urandom_range(0, 2));
      d = 8'($urandom);
      if (a == 2'd2) d = {5'd0, d[2:0]};
      if (a == 2'd0 && $urandom_range(0, 3) != 0) d[4] = 1'b0;
      if (a == 2'd0 && $urandom_range(0, 2) != 0) d[5] = 1'b0;
      if (r < 55)      cyc("R3", 1'($urandom), 1'b0, 1'b0, 2'd0, 8'h00);
      else if (r < 85) cyc(a == 2'd0 ? "R5" : "R3", 1'($urandom), 1'b1, 1'b0, a, 8'h00);
      else if (r < 97) cyc("R10", 1'($urandom), 1'b0, 1'b1, a, d);
      else             cyc("R10", 1'($urandom), 1'b0, 1'b1, 2'd2, {5'd0, d[2:0]});
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule